// File: doc/BRIEF.md
# Serial Peripheral Master with APB Register Port and Word Queues

This block is a full-duplex serial master that sits on an APB bus as a slave. Software or a DMA engine writes bytes into an 8-entry transmit queue. A small two-state engine takes each byte and shifts it out MSB first on `mosi`. In the same transfer it shifts a byte in from `miso` and stores it in an 8-entry receive queue. A programmable divider derives the serial clock from `pclk`. The idle level and the sampling edge of that clock can be configured.

The engine always inserts one idle serial-clock period between consecutive words. It produces all four clock modes from one base waveform, which is inverted for polarity and for phase. Software can poll the status word, or it can let the DMA request lines move the data. Three status conditions can raise a single interrupt when enabled.

Register word addresses are selected by `paddr[3:2]`: 0 holds the control word, 1 holds the status word and 2 is the data port.

Top module: `spi_apb_master`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0x01 (only the transmit-empty bit set), `sclk` is low, and `irq`, `dma_tx_req` and `dma_rx_req` are low.
- R2: The control word reads back exactly as written. Its fields are: divider in bits 7:0, polarity in bit 8, phase in bit 9, interrupt enables in bits 12:10 (bit 10 transmit-empty, bit 11 receive-not-empty, bit 12 overrun), transmit DMA enable in bit 13 and receive DMA enable in bit 14.
- R3: While no word is in flight, `sclk` rests at the polarity bit.
- R4: Each half period of `sclk` lasts DIV+1 `pclk` cycles, and every word produces exactly 16 `sclk` edges.
- R5: The byte written to the data port leaves on `mosi` MSB first. It is valid on the first `sclk` edge of each bit when phase is 0, and on the second edge when phase is 1.
- R6: The bits on `miso` are captured on the same sampling edges. The assembled byte is returned by a read of the data port.
- R7: With phase 0, when a second word is already queued, its first `sclk` edge comes 3*(DIV+1)+1 `pclk` cycles after the last edge of the previous word. This is one idle serial period, one load cycle and the leading half bit. `busy` is never re-raised in the cycle right after it falls.
- R8: The transmit queue holds 8 bytes. A data-port write while it is full is dropped: the byte is never sent and the queue stays full.
- R9: The receive queue holds 8 bytes. A word that completes while it is full is discarded and sets the overrun flag. Writing 1 to status bit 3 clears the flag.
- R10: Status bits: bit 0 transmit queue empty, bit 1 transmit queue full, bit 2 receive queue not empty, bit 3 overrun, bit 4 busy (a word is being shifted).
- R11: `irq` is high whenever an enabled condition (transmit-empty, receive-not-empty or overrun) holds.
- R12: `dma_tx_req` is high while transmit DMA is enabled and the transmit queue is not full. `dma_rx_req` is high while receive DMA is enabled and the receive queue holds data. Both are low in the cycle after `dma_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 4 | Byte address; bits 3:2 pick the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Request to fill the transmit queue |
| dma_rx_req | output | 1 | Request to drain the receive queue |
| dma_ack | input | 1 | DMA acknowledge; both requests fall for one cycle |

## Verification
Register and status effects are visible on the cycle after the APB access edge. The bench reads them with a fresh APB read, and it captures `prdata` one time unit after the access-phase falling edge, before the pop edge. Serial timing is measured by a slave model that timestamps `sclk` edges, so the half period (R4) and the inter-word spacing (R7) are compared with exact nanosecond values derived from DIV. The `irq` and DMA request outputs follow their state registers by one edge, so they are sampled at the falling edge after the write or the acknowledge. The acknowledge drop is checked at the very next falling edge and its release one edge later.

// File: rtl/spi_apb_master.sv
module spi_apb_master #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq,
  output logic        dma_tx_req,
  output logic        dma_rx_req,
  input  logic        dma_ack
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = $clog2(2 * DW);
  localparam logic [AW:0] FULLC = (AW + 1)'(DEPTH);
  localparam logic [HW-1:0] LASTH = HW'(2 * DW - 1);

  logic [DIVW-1:0] div_q;
  logic cpol_q, cpha_q;
  logic [2:0] ie_q;
  logic [1:0] dmaen_q;

  wire acc    = psel & penable;
  wire wr     = acc & pwrite;
  wire rd     = acc & ~pwrite;
  wire s_ctrl = paddr[3:2] == 2'd0;
  wire s_stat = paddr[3:2] == 2'd1;
  wire s_data = paddr[3:2] == 2'd2;
  wire tx_wr  = wr & s_data;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  wire [AW:0] tx_cnt = tx_wp - tx_rp;
  wire [AW:0] rx_cnt = rx_wp - rx_rp;
  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == FULLC;
  wire rx_empty = rx_cnt == '0;
  wire rx_full  = rx_cnt == FULLC;

  logic busy, ovr, ack_q;
  logic [1:0] gap;
  logic [DIVW-1:0] cnt;
  logic [HW-1:0] half;
  logic [DW-1:0] tsh, rsh;

  wire tick      = cnt == div_q;
  wire start     = ~busy & (gap == 2'd0) & ~tx_empty;
  wire word_done = busy & tick & (half == LASTH);
  wire tx_push   = tx_wr & ~tx_full;
  wire rx_push   = word_done & ~rx_full;
  wire rx_pop    = rd & s_data & ~rx_empty;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      div_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; ie_q <= '0; dmaen_q <= '0;
    end else if (wr & s_ctrl) begin
      div_q   <= pwdata[DIVW-1:0];
      cpol_q  <= pwdata[DIVW];
      cpha_q  <= pwdata[DIVW+1];
      ie_q    <= pwdata[DIVW+4:DIVW+2];
      dmaen_q <= pwdata[DIVW+6:DIVW+5];
    end

  always_ff @(posedge pclk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= pwdata[DW-1:0];
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rsh;
  end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      ovr <= 1'b0; ack_q <= 1'b0;
    end else begin
      tx_wp <= tx_wp + (AW + 1)'(tx_push);
      tx_rp <= tx_rp + (AW + 1)'(start);
      rx_wp <= rx_wp + (AW + 1)'(rx_push);
      rx_rp <= rx_rp + (AW + 1)'(rx_pop);
      ack_q <= dma_ack;
      if (word_done & rx_full) ovr <= 1'b1;
      else if (wr & s_stat & pwdata[3]) ovr <= 1'b0;
    end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      busy <= 1'b0; gap <= '0; cnt <= '0; half <= '0; tsh <= '0; rsh <= '0;
    end else begin
      cnt <= (start | tick) ? '0 : cnt + 1'b1;
      if (start) begin
        busy <= 1'b1;
        half <= '0;
        tsh  <= tx_mem[tx_rp[AW-1:0]];
      end else if (busy & tick) begin
        half <= half + 1'b1;
        if (!half[0]) rsh <= {rsh[DW-2:0], miso};
        else          tsh <= tsh << 1;
        if (half == LASTH) begin
          busy <= 1'b0;
          gap  <= 2'd2;
        end
      end else if (!busy & tick & (gap != 2'd0)) begin
        gap <= gap - 1'b1;
      end
    end

  assign sclk = cpol_q ^ (busy & (half[0] ^ cpha_q));
  assign mosi = tsh[DW-1];
  assign irq  = |(ie_q & {ovr, ~rx_empty, tx_empty});
  assign dma_tx_req = dmaen_q[0] & ~tx_full & ~ack_q;
  assign dma_rx_req = dmaen_q[1] & ~rx_empty & ~ack_q;

  always_comb begin
    prdata = '0;
    if (s_ctrl)      prdata = 32'({dmaen_q, ie_q, cpha_q, cpol_q, div_q});
    else if (s_stat) prdata = {27'd0, busy, ovr, ~rx_empty, tx_full, tx_empty};
    else if (s_data) prdata = 32'(rx_mem[rx_rp[AW-1:0]]);
  end

  wire unused_ok = ^{pwdata[31:DIVW+7], paddr[1:0]};
endmodule

module spi_apb_master_chk (
  input logic pclk,
  input logic presetn,
  input logic busy,
  input logic mosi,
  input logic half_lsb,
  input logic dma_ack,
  input logic dma_tx_req,
  input logic dma_rx_req,
  input logic rx_full,
  input logic word_done,
  input logic ovr,
  input logic tx_full,
  input logic tx_wr,
  input logic start
);
  // R12
  ack_drop_chk: assert property (@(posedge pclk) disable iff (!presetn)
    dma_ack |=> (!dma_tx_req && !dma_rx_req));
  // R9
  ovr_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_full && word_done) |=> ovr);
  // R8
  tx_full_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (tx_full && tx_wr && !start) |=> tx_full);
  // R7
  idle_gap_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(busy) |=> !busy);
  // R5
  mosi_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (busy && !half_lsb) |=> $stable(mosi));
endmodule

bind spi_apb_master spi_apb_master_chk u_chk (
  .pclk(pclk), .presetn(presetn), .busy(busy), .mosi(mosi), .half_lsb(half[0]),
  .dma_ack(dma_ack), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
  .rx_full(rx_full), .word_done(word_done), .ovr(ovr), .tx_full(tx_full),
  .tx_wr(tx_wr), .start(start)
);

// File: tb/tb_spi_apb_master.sv
`timescale 1ns/1ps
module tb_spi_apb_master;
  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic sclk, mosi, miso, irq, dma_tx_req, dma_rx_req, dma_ack = 0;

  spi_apb_master dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .dma_ack(dma_ack));

  always #4 pclk = ~pclk;

  int total = 0, bad = 0;
  bit finished = 0;

  // slave model
  logic armed = 0, scpha = 0;
  int ecnt = 0, words = 0;
  logic [8:0] ss = '0;
  logic [7:0] cap = '0, resp = '0;
  logic [7:0] cap_log [16];
  time t_e2 = 0, t_end = 0, hp = 0, gapt = 0;
  assign miso = ss[8];

  always @(sclk) if (armed) begin
    ecnt = ecnt + 1;
    if (ecnt == 1 && words > 0) gapt = $time - t_end;
    if (ecnt == 2) t_e2 = $time;
    if (ecnt == 3) hp = $time - t_e2;
    if (ecnt[0] ^ scpha) cap = {cap[6:0], mosi};
    else ss = ss << 1;
    if (ecnt == 16) begin
      if (words < 16) cap_log[words] = cap;
      words = words + 1;
      ecnt = 0;
      t_end = $time;
      resp = resp + 8'd1;
      ss = scpha ? {1'b0, resp} : {resp, 1'b0};
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic setup(input logic [31:0] ctrl, input logic [7:0] r0);
    armed = 0;
    apb_write(4'h0, ctrl);
    @(negedge pclk);
    ecnt = 0; words = 0; scpha = ctrl[9]; resp = r0; cap = '0;
    ss = scpha ? {1'b0, r0} : {r0, 1'b0};
    armed = 1;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = '0;
    do apb_read(4'h4, s); while (!(s[4] == 1'b0 && s[0] == 1'b1));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // cpol, cpha, div, tx byte, slave reply
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 8'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 8'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'd7, 8'h01, 8'h80},
    {1'b1, 1'b1, 8'd0, 8'hFF, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge pclk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge pclk);
    presetn = 1;

    // R1 reset state
    @(negedge pclk);
    chk(sclk == 0 && irq == 0 && dma_tx_req == 0 && dma_rx_req == 0, "R1 pins",
        {sclk, irq, dma_tx_req, dma_rx_req}, 0);
    apb_read(4'h0, d); chk(d == 0, "R1 ctrl", d, 0);
    apb_read(4'h4, d); chk(d == 32'h01, "R1 status", d, 32'h01);

    // R2 readback, R11 transmit-empty interrupt
    apb_write(4'h0, 32'h0000_0405);
    apb_read(4'h0, d); chk(d == 32'h0405, "R2 readback", d, 32'h0405);
    chk(irq == 1, "R11 tx-empty irq", irq, 1);
    apb_write(4'h0, 32'h0);
    @(negedge pclk); chk(irq == 0, "R11 irq disabled", irq, 0);

    // vector table: R3 R4 R5 R6
    foreach (VEC[i]) begin
      logic [25:0] v;
      logic [7:0] dv;
      v = VEC[i];
      dv = v[23:16];
      setup({22'd0, v[24], v[25], dv}, v[7:0]);
      chk(sclk == v[25], "R3 idle level", sclk, v[25]);
      apb_write(4'h8, {24'd0, v[15:8]});
      wait_idle();
      chk(words == 1, "R4 sixteen edges", words, 1);
      chk(hp == 8 * (dv + 1), "R4 half period", hp, 8 * (dv + 1));
      chk(cap_log[0] == v[15:8], "R5 mosi byte", cap_log[0], v[15:8]);
      apb_read(4'h8, d); chk(d[7:0] == v[7:0], "R6 miso byte", d, v[7:0]);
      chk(sclk == v[25], "R3 rest after word", sclk, v[25]);
    end

    // R7 back-to-back spacing, phase 0, DIV=1
    setup(32'h0000_0001, 8'h40);
    apb_write(4'h8, 32'h11);
    apb_write(4'h8, 32'h22);
    wait_idle();
    chk(words == 2, "R7 two words", words, 2);
    chk(gapt == 8 * (3 * 2 + 1), "R7 idle spacing", gapt, 8 * 7);
    chk(cap_log[1] == 8'h22, "R7 second byte", cap_log[1], 8'h22);
    apb_read(4'h8, d); apb_read(4'h8, d);
    chk(d[7:0] == 8'h41, "R6 second reply", d, 8'h41);

    // R8 / R9 / R10 queue limits, DIV=3
    setup(32'h0000_0003, 8'h10);
    for (int k = 0; k < 10; k++) apb_write(4'h8, 32'h20 + k);
    apb_read(4'h4, d); chk(d[4:0] == 5'b10010, "R8 R10 full and busy", d, 5'b10010);
    wait_idle();
    chk(words == 9, "R8 dropped write not sent", words, 9);
    chk(cap_log[8] == 8'h28, "R8 last sent byte", cap_log[8], 8'h28);
    apb_read(4'h4, d); chk(d[4:0] == 5'b01101, "R9 R10 overrun status", d, 5'b01101);
    apb_write(4'h0, 32'h0000_1003);
    @(negedge pclk); chk(irq == 1, "R11 overrun irq", irq, 1);
    for (int k = 0; k < 8; k++) begin
      apb_read(4'h8, d); chk(d[7:0] == 8'h10 + k, "R9 kept words", d, 8'h10 + k);
    end
    apb_read(4'h4, d); chk(d[4:0] == 5'b01001, "R10 drained", d, 5'b01001);
    apb_write(4'h4, 32'h8);
    apb_read(4'h4, d); chk(d[4:0] == 5'b00001, "R9 overrun cleared", d, 5'b00001);
    chk(irq == 0, "R11 irq after clear", irq, 0);

    // R11 receive-not-empty, R12 receive DMA
    setup(32'h0000_4800, 8'h66);
    apb_write(4'h8, 32'h33);
    wait_idle();
    @(negedge pclk);
    chk(dma_rx_req == 1, "R12 rx request", dma_rx_req, 1);
    chk(irq == 1, "R11 rx-not-empty irq", irq, 1);
    apb_read(4'h8, d); chk(d[7:0] == 8'h66, "R6 dma reply", d, 8'h66);
    @(negedge pclk); chk(dma_rx_req == 0, "R12 rx request off", dma_rx_req, 0);

    // R12 transmit DMA and acknowledge
    apb_write(4'h0, 32'h0000_2000);
    @(negedge pclk); chk(dma_tx_req == 1, "R12 tx request", dma_tx_req, 1);
    dma_ack = 1;
    @(negedge pclk); dma_ack = 0;
    chk(dma_tx_req == 0, "R12 drop after ack", dma_tx_req, 0);
    @(negedge pclk); chk(dma_tx_req == 1, "R12 request back", dma_tx_req, 1);

    finished = 1;
    summary();
  end
endmodule